// File: doc/BRIEF.md
# Streaming Separable 2D Image Filter

This block filters a raster-order pixel stream with a two-dimensional kernel. It takes one pixel per clock and returns one filtered pixel per clock, with a fixed latency and no stalls. The kernel is not stored as an n×n matrix. It is written as a sum of K outer products, each of a column vector and a row vector. Every product term is its own branch. A branch first applies its row vector across the current line. It then keeps the row results of the last N−1 lines in line buffers and applies its column vector down that stack. A final stage adds the K branch results, rounds them and clamps them to the output width. A K-term, N-tap kernel therefore needs 2·N·K multipliers rather than N·N.

The window is anchored at the newest pixel. The output for the pixel at row r and column c combines the inputs at rows r−i and columns c−j, with i and j in 0..N−1. Positions above the first row or left of the first column count as zero, so every input pixel yields exactly one output and the end of a frame needs no flush. Line boundaries come from an end-of-line flag on the last pixel of each line. A start-of-frame flag on the first pixel restarts the row count. Both flags, together with the valid strobe, leave the block aligned with the pixel they belong to.

Coefficients are signed fixed-point parameters with FRAC_W fraction bits. Entry (b, j) of either vector set sits at bits [(b·N+j)·COEF_W +: COEF_W]. Branch b's row vector is ROW_COEFS and its column vector is COL_COEFS. Tap index 0 is the newest pixel for rows and the current line for columns.

Top module: `sep_conv2d`

## Requirements
- R1: While rst_n is low, and until the first accepted pixel has crossed the pipeline, out_valid, out_sof and out_eol are low.
- R2: out_valid, out_sof and out_eol equal in_valid, in_sof and in_eol as presented exactly 3 clock cycles earlier. Every accepted pixel gives exactly one output, with no stall.
- R3: For a pixel at row r and column c, the unrounded result is the sum over b, i, j of COL[b][i]·ROW[b][j]·pix(r−i, c−j). ROW[b][j] is the signed field at bits [(b·N+j)·COEF_W +: COEF_W] of ROW_COEFS, and COL[b][i] is taken from COL_COEFS the same way. Each coefficient has FRAC_W fraction bits, so the sum carries 2·FRAC_W fraction bits.
- R4: Positions with c−j < 0 contribute zero. The pixel after one flagged with in_eol is column 0.
- R5: Positions with r−i < 0 contribute zero. A pixel with in_sof is row 0, column 0, and no data from an earlier frame reaches its outputs.
- R6: The full-precision sum is rounded by adding 2^(2·FRAC_W−1) and shifting right arithmetically by 2·FRAC_W, so that ties go toward positive infinity.
- R7: The rounded value is saturated to the signed OUT_W range.
- R8: Cycles with in_valid low advance no window, so the results equal those of a gap-free stream. out_pix holds its last value while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | PIX_W | Unsigned input pixel |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output pixel strobe |
| out_pix | output | OUT_W | Signed, rounded and saturated result |
| out_sof | output | 1 | Start-of-frame flag aligned with out_pix |
| out_eol | output | 1 | End-of-line flag aligned with out_pix |

## Verification
Every result and flag is due three rising edges after the edge that accepts its pixel: one edge for the row pass, one for the column pass and one for the sum and clamp. The bench computes each expected value from its own copy of the frame when it drives the pixel. It stores that value three slots ahead in a small ring and compares it at the falling edge three cycles later. In every idle slot it checks that the strobes are low and that the data has not moved. This holds for the idle cycles inserted inside a line as well.

// File: rtl/sep_conv_pkg.sv
package sep_conv_pkg;

  // Sideband that travels with every pixel through the pipeline.
  typedef struct packed {
    logic valid;
    logic sof;
    logic eol;
  } pix_tag_t;

endpackage

// File: rtl/sep_conv_pos.sv
// Raster position tracking: column index and saturated row count of the
// incoming pixel, registered into stage 1 alongside the row-pass result.
module sep_conv_pos
  import sep_conv_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int N     = 3,
  parameter int CW    = 4,
  parameter int RW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pix_tag_t      in_tag,
  output logic          first_col,
  output pix_tag_t      s1_tag,
  output logic [CW-1:0] s1_col,
  output logic [RW-1:0] s1_row
);

  localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(N - 1);

  logic [CW-1:0] col_q, col_d, col_now;
  logic [RW-1:0] row_q, row_d, row_now;

  // Next-state logic
  always_comb begin
    col_now = in_tag.sof ? '0 : col_q;
    row_now = in_tag.sof ? '0 : row_q;
    col_d   = col_q;
    row_d   = row_q;
    if (in_tag.valid) begin
      if (in_tag.eol) begin
        col_d = '0;
        row_d = (row_now == ROW_LAST) ? row_now : row_now + RW'(1);
      end else begin
        col_d = (col_now == COL_LAST) ? col_now : col_now + CW'(1);
        row_d = row_now;
      end
    end
  end

  assign first_col = (col_now == '0);

  // Position state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  // Stage-1 sideband
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_tag <= '0;
      s1_col <= '0;
      s1_row <= '0;
    end else begin
      s1_tag <= in_tag;
      if (in_tag.valid) begin
        s1_col <= col_now;
        s1_row <= row_now;
      end
    end
  end

endmodule

// File: rtl/sep_conv_hpass.sv
// Row pass: one shared history of the last N-1 pixels of the current line,
// and K dot products against the per-branch row vectors.
module sep_conv_hpass #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int N      = 3,
  parameter int K      = 2,
  parameter int H_W    = 20,
  parameter logic [K*N*COEF_W-1:0] ROW_COEFS = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    first_col,
  input  logic [PIX_W-1:0]        in_pix,
  output logic [K-1:0][H_W-1:0]   h_out
);

  logic signed [PIX_W:0]   cur    [N];
  logic signed [PIX_W:0]   hist_q [N-1];
  logic signed [H_W-1:0]   h_d    [K];

  // Current row window: tap 0 is the arriving pixel, older taps are zero
  // at the start of a line.
  always_comb begin
    cur[0] = $signed({1'b0, in_pix});
    for (int j = 1; j < N; j++) begin
      cur[j] = first_col ? '0 : hist_q[j-1];
    end
  end

  // K row dot products at full precision
  always_comb begin
    logic signed [COEF_W-1:0] cf;
    cf = '0;
    for (int b = 0; b < K; b++) begin
      h_d[b] = '0;
      for (int j = 0; j < N; j++) begin
        cf     = ROW_COEFS[(b*N+j)*COEF_W +: COEF_W];
        h_d[b] = h_d[b] + H_W'(cf) * H_W'(cur[j]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N-1; j++) hist_q[j] <= '0;
    end else if (in_valid) begin
      for (int j = 0; j < N-1; j++) hist_q[j] <= cur[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_out <= '0;
    end else if (in_valid) begin
      for (int b = 0; b < K; b++) h_out[b] <= h_d[b];
    end
  end

endmodule

// File: rtl/sep_conv_vpass.sv
// Column pass for one branch: N-1 line buffers of row-pass results and a
// dot product with the branch's column vector.
module sep_conv_vpass #(
  parameter int IMG_W  = 16,
  parameter int N      = 3,
  parameter int COEF_W = 8,
  parameter int H_W    = 20,
  parameter int V_W    = 31,
  parameter int CW     = 4,
  parameter int RW     = 2,
  parameter logic [N*COEF_W-1:0] COL_COEFS = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic signed [H_W-1:0] h_in,
  input  logic [CW-1:0]         col,
  input  logic [RW-1:0]         row,
  output logic signed [V_W-1:0] v_out
);

  logic signed [H_W-1:0] lb [N-1][IMG_W];
  logic signed [H_W-1:0] vt [N];
  logic signed [V_W-1:0] v_d;

  // Vertical window: tap 0 is the current line, tap i is i lines up and
  // is zero above the first row of the frame.
  always_comb begin
    vt[0] = h_in;
    for (int i = 1; i < N; i++) begin
      vt[i] = (row >= RW'(i)) ? lb[i-1][col] : '0;
    end
  end

  always_comb begin
    logic signed [COEF_W-1:0] cf;
    cf  = '0;
    v_d = '0;
    for (int i = 0; i < N; i++) begin
      cf  = COL_COEFS[i*COEF_W +: COEF_W];
      v_d = v_d + V_W'(cf) * V_W'(vt[i]);
    end
  end

  // Line-buffer storage: each column slot shifts one line deeper.
  always_ff @(posedge clk) begin
    if (en) begin
      lb[0][col] <= h_in;
      for (int i = 1; i < N-1; i++) lb[i][col] <= lb[i-1][col];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out <= '0;
    end else if (en) begin
      v_out <= v_d;
    end
  end

endmodule

// File: rtl/sep_conv_sum.sv
// Branch summation, rounding and saturation.
module sep_conv_sum #(
  parameter int K      = 2,
  parameter int V_W    = 31,
  parameter int S_W    = 33,
  parameter int OUT_W  = 10,
  parameter int FRAC_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [K-1:0][V_W-1:0]   v_in,
  output logic signed [OUT_W-1:0] res
);

  localparam int SH = 2 * FRAC_W;
  localparam logic signed [S_W-1:0] HALF = S_W'(1) << (SH - 1);
  localparam logic signed [S_W-1:0] MAXV = {{(S_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [S_W-1:0] MINV = {{(S_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [S_W-1:0]   total;
  logic signed [S_W-1:0]   rnd;
  logic signed [OUT_W-1:0] res_d;

  if (K == 1) begin : g_single
    assign total = S_W'($signed(v_in[0]));
  end else begin : g_tree
    always_comb begin
      total = '0;
      for (int b = 0; b < K; b++) total = total + S_W'($signed(v_in[b]));
    end
  end

  always_comb begin
    rnd = (total + HALF) >>> SH;
    if (rnd > MAXV) begin
      res_d = MAXV[OUT_W-1:0];
    end else if (rnd < MINV) begin
      res_d = MINV[OUT_W-1:0];
    end else begin
      res_d = rnd[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
    end else if (en) begin
      res <= res_d;
    end
  end

endmodule

// File: rtl/sep_conv2d.sv
// Streaming separable 2D filter, sum of K outer-product branches.
module sep_conv2d
  import sep_conv_pkg::*;
#(
  parameter int IMG_W  = 16,
  parameter int N      = 3,
  parameter int K      = 2,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int FRAC_W = 4,
  parameter int OUT_W  = 10,
  parameter logic [K*N*COEF_W-1:0] ROW_COEFS = 48'hF0_00_10_04_08_04,
  parameter logic [K*N*COEF_W-1:0] COL_COEFS = 48'h10_F0_10_04_08_04
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [PIX_W-1:0]        in_pix,
  input  logic                    in_sof,
  input  logic                    in_eol,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_pix,
  output logic                    out_sof,
  output logic                    out_eol
);

  localparam int CW     = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int RW     = $clog2(N);
  localparam int GROW_N = $clog2(N) + 1;
  localparam int H_W    = PIX_W + 1 + COEF_W + GROW_N;
  localparam int V_W    = H_W + COEF_W + GROW_N;
  localparam int S_W    = V_W + $clog2(K) + 1;

  pix_tag_t             in_tag, s1_tag, s2_tag, out_tag;
  logic                 first_col;
  logic [CW-1:0]        s1_col;
  logic [RW-1:0]        s1_row;
  logic [K-1:0][H_W-1:0] h_all;
  logic [K-1:0][V_W-1:0] v_all;

  assign in_tag = '{valid: in_valid, sof: in_sof, eol: in_eol};

  sep_conv_pos #(
    .IMG_W(IMG_W), .N(N), .CW(CW), .RW(RW)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .in_tag(in_tag), .first_col(first_col),
    .s1_tag(s1_tag), .s1_col(s1_col), .s1_row(s1_row)
  );

  sep_conv_hpass #(
    .PIX_W(PIX_W), .COEF_W(COEF_W), .N(N), .K(K), .H_W(H_W),
    .ROW_COEFS(ROW_COEFS)
  ) u_hpass (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .first_col(first_col),
    .in_pix(in_pix), .h_out(h_all)
  );

  for (genvar b = 0; b < K; b++) begin : g_branch
    sep_conv_vpass #(
      .IMG_W(IMG_W), .N(N), .COEF_W(COEF_W), .H_W(H_W), .V_W(V_W),
      .CW(CW), .RW(RW),
      .COL_COEFS(COL_COEFS[b*N*COEF_W +: N*COEF_W])
    ) u_vpass (
      .clk(clk), .rst_n(rst_n), .en(s1_tag.valid),
      .h_in($signed(h_all[b])), .col(s1_col), .row(s1_row),
      .v_out(v_all[b])
    );
  end

  sep_conv_sum #(
    .K(K), .V_W(V_W), .S_W(S_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)
  ) u_sum (
    .clk(clk), .rst_n(rst_n), .en(s2_tag.valid), .v_in(v_all), .res(out_pix)
  );

  // Sideband pipeline for stages 2 and 3
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_tag  <= '0;
      out_tag <= '0;
    end else begin
      s2_tag  <= s1_tag;
      out_tag <= s2_tag;
    end
  end

  assign out_valid = out_tag.valid;
  assign out_sof   = out_tag.sof;
  assign out_eol   = out_tag.eol;

endmodule

// File: rtl/sep_conv2d_chk.sv
// Protocol checks on the filter ports, bound into every instance.
module sep_conv2d_chk #(
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_eol,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_pix,
  input logic             out_sof,
  input logic             out_eol
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !out_sof && !out_eol)); // R1

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2

  AST_SOF_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_sof == $past(in_sof, 3))); // R2

  AST_EOL_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_eol == $past(in_eol, 3))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst != 2'd0) && !out_valid) |-> $stable(out_pix)); // R8

endmodule

bind sep_conv2d sep_conv2d_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_eol(in_eol), .out_valid(out_valid), .out_pix(out_pix),
  .out_sof(out_sof), .out_eol(out_eol)
);

// File: tb/sep_conv2d_tb.sv
`timescale 1ns/1ps
module sep_conv2d_tb;

  localparam int W   = 8;
  localparam int H   = 5;
  localparam int N   = 3;
  localparam int K   = 2;
  localparam int F   = 4;
  localparam int OW  = 8;
  localparam int LAT = 3;
  localparam logic [47:0] ROWP = 48'hF0_00_10_04_08_04;
  localparam logic [47:0] COLP = 48'h10_F0_10_04_08_04;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n, in_valid, in_sof, in_eol;
  logic [7:0]           in_pix;
  logic                 out_valid, out_sof, out_eol;
  logic signed [OW-1:0] out_pix;

  sep_conv2d #(
    .IMG_W(W), .N(N), .K(K), .PIX_W(8), .COEF_W(8), .FRAC_W(F), .OUT_W(OW),
    .ROW_COEFS(ROWP), .COL_COEFS(COLP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_sof(in_sof), .in_eol(in_eol), .out_valid(out_valid),
    .out_pix(out_pix), .out_sof(out_sof), .out_eol(out_eol)
  );

  int          n_chk, n_fail, cyc;
  bit          done;
  int          img [H][W];
  bit          ev [8];
  bit          es [8];
  bit          ee [8];
  longint      ed [8];
  string       et [8];
  longint      last_pix;
  int unsigned seed;

  function automatic int coef(input logic [47:0] v, input int b, input int j);
    logic signed [7:0] c;
    c = v[(b*N+j)*8 +: 8];
    return int'(c);
  endfunction

  // Expected output from the requirements: sum of outer products, then
  // round half up and clamp.
  function automatic longint ref_pix(input int r, input int c);
    longint t, q;
    t = 0;
    for (int b = 0; b < K; b++)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (r - i >= 0 && c - j >= 0)
            t += longint'(coef(COLP, b, i) * coef(ROWP, b, j)) * longint'(img[r-i][c-j]);
    q = (t + (longint'(1) << (2*F-1))) >>> (2*F);
    if (q > 127) q = 127;
    if (q < -128) q = -128;
    return q;
  endfunction

  function automatic int pix_of(input int pat, input int r, input int c);
    case (pat)
      0: return (r*7 + c*5) % 64;
      1: return (r == 2 && c == 3) ? 100 : 0;
      2: begin
        seed = seed * 1103515245 + 12345;
        return int'((seed >> 16) & 127);
      end
      default: return (c % 4 == 0) ? 255 : 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] p, input bit s, input bit e,
                      input longint d, input string tag);
    int    slot;
    string vtag;
    @(negedge clk);
    slot = cyc % 8;
    vtag = (cyc < LAT) ? "R1" : "R2";
    check(out_valid === ev[slot], vtag, "out_valid", longint'(out_valid), longint'(ev[slot]));
    check(out_sof === es[slot], vtag, "out_sof", longint'(out_sof), longint'(es[slot]));
    check(out_eol === ee[slot], vtag, "out_eol", longint'(out_eol), longint'(ee[slot]));
    if (ev[slot]) begin
      check(longint'(out_pix) == ed[slot], et[slot], "out_pix", longint'(out_pix), ed[slot]);
      last_pix = longint'(out_pix);
    end else begin
      check(longint'(out_pix) == last_pix, "R8", "idle hold", longint'(out_pix), last_pix);
    end
    in_valid = v;
    in_pix   = p;
    in_sof   = s;
    in_eol   = e;
    slot     = (cyc + LAT) % 8;
    ev[slot] = v;
    es[slot] = v && s;
    ee[slot] = v && e;
    ed[slot] = d;
    et[slot] = tag;
    cyc++;
  endtask

  task automatic run_frame(input int pat, input bit gaps, input string tag);
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        int    p;
        string t;
        p = pix_of(pat, r, c);
        img[r][c] = p;
        t = (c < N-1) ? "R4" : (r < N-1) ? "R5" : tag;
        step(1'b1, 8'(p), (r == 0 && c == 0), (c == W-1), ref_pix(r, c), t);
        if (gaps && (c % 3 == 1)) step(1'b0, 8'd0, 1'b0, 1'b0, 0, "R8");
      end
    end
  endtask

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    cyc      = 0;
    done     = 1'b0;
    last_pix = 0;
    seed     = 32'd1;
    for (int s = 0; s < 8; s++) begin
      ev[s] = 1'b0; es[s] = 1'b0; ee[s] = 1'b0; ed[s] = 0; et[s] = "R2";
    end
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_pix   = '0;
    in_sof   = 1'b0;
    in_eol   = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(!out_valid && !out_sof && !out_eol, "R1", "reset quiet",
            longint'(out_valid), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    run_frame(0, 1'b0, "R3");  // ramp
    run_frame(1, 1'b0, "R6");  // impulse: half-unit products round up
    run_frame(2, 1'b0, "R6");  // random, both signs of ties
    run_frame(3, 1'b0, "R7");  // column stripes drive both clamps
    run_frame(0, 1'b0, "R3");  // border rows after a bright frame (R5)
    run_frame(2, 1'b1, "R8");  // random with idle cycles inside lines
    repeat (LAT + 2) step(1'b0, 8'd0, 1'b0, 1'b0, 0, "R8");

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule